// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It divides a fast input clock by an integer ratio that can change on every output period. A first-order accumulator picks INT or INT+1 for each period, and over time the average ratio becomes INT + FRAC/MOD. MOD is a programmable modulus of up to 4095. It does not have to be a power of two.

Software or a sequencer presents the three values on parallel inputs and pulses a load strobe. The block clamps the values into their legal ranges and holds them as pending. The pending set is applied as a whole at the next output-period boundary, and the accumulator is cleared at that point. Each period ends with a single-clock pulse on the divided output. A status port shows the ratio of the period currently being counted.

Top module: `fracn_div`

## Requirements
- R1: While reset is held and after it is released, `ratio` reads 31 and `div_pulse` is low; until the first load, every period divides by 31.
- R2: `div_pulse` is high for exactly one clock at the last clock of each period. The number of clocks from the clock after one pulse up to and including the next pulse equals the `ratio` value shown during that period, and `ratio` only changes on the clock after a pulse.
- R3: Each period divides by INT+1 when the accumulator (cleared to 0 on apply) plus FRAC reaches MOD or more, and MOD is then subtracted from it; otherwise the period divides by INT and the sum is kept.
- R4: With constant parameters, exactly FRAC of every MOD consecutive periods counted from an apply use INT+1.
- R5: A load is captured on the clock edge where `load` is high. INT, FRAC and MOD take effect together, starting with the period that follows the next pulse, and the accumulator restarts from 0.
- R6: An INT below 31 is used as 31.
- R7: A MOD below 2 is used as 2.
- R8: A FRAC equal to or greater than the (clamped) MOD is used as MOD-1.
- R9: A load captured on the clock edge of a boundary takes effect only at the following boundary. When several loads land before one boundary, the last one is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Strobe that captures the parameter inputs |
| int_in | input | 9 | Integer part of the ratio |
| frac_in | input | 12 | Fractional numerator |
| mod_in | input | 12 | Fractional modulus |
| div_pulse | output | 1 | One-clock pulse at the end of each period |
| ratio | output | 10 | Ratio of the period being counted |

## Verification
The hardest case to reach is a load strobe that falls on the same clock edge as a period boundary, possibly followed by a second load before the next boundary. The stimulus waits until the pulse is visible, then raises the strobe on that same clock, and again on the next clock with different values. It then checks that the period in progress keeps the old ratio and that the following periods follow the second value set from a cleared accumulator. Random parameter sets, including values that need clamping, are counted over a full modulus of periods to check the exact number of INT+1 periods.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int INT_W  = 9;
  localparam int MOD_W  = 12;
  localparam int RAT_W  = INT_W + 1;
  localparam int INT_LO = 31;
  localparam int INT_HI = 511;
  localparam int MOD_LO = 2;

  typedef struct packed {
    logic [INT_W-1:0] int_v;
    logic [MOD_W-1:0] frac_v;
    logic [MOD_W-1:0] mod_v;
  } fracn_cfg_t;
endpackage

// File: rtl/fracn_clamp.sv
module fracn_clamp
  import fracn_pkg::*;
(
  input  logic [INT_W-1:0] raw_int,
  input  logic [MOD_W-1:0] raw_frac,
  input  logic [MOD_W-1:0] raw_mod,
  output fracn_cfg_t       cfg_c
);
  logic [INT_W-1:0] int_lo_fix;
  logic [INT_W-1:0] int_fix;
  logic [MOD_W-1:0] mod_fix;
  logic [MOD_W-1:0] frac_fix;

  always_comb begin
    int_lo_fix = (raw_int < INT_W'(INT_LO)) ? INT_W'(INT_LO) : raw_int;
  end

  // The upper clamp exists only when the field can exceed the legal top.
  generate
    if (INT_HI < (1 << INT_W) - 1) begin : g_hi_clamp
      always_comb begin
        int_fix = (int_lo_fix > INT_W'(INT_HI)) ? INT_W'(INT_HI) : int_lo_fix;
      end
    end else begin : g_no_hi_clamp
      always_comb begin
        int_fix = int_lo_fix;
      end
    end
  endgenerate

  always_comb begin
    mod_fix  = (raw_mod < MOD_W'(MOD_LO)) ? MOD_W'(MOD_LO) : raw_mod;
    frac_fix = (raw_frac >= mod_fix) ? (mod_fix - MOD_W'(1)) : raw_frac;
    cfg_c.int_v  = int_fix;
    cfg_c.frac_v = frac_fix;
    cfg_c.mod_v  = mod_fix;
  end
endmodule

// File: rtl/fracn_cfg_hold.sv
module fracn_cfg_hold
  import fracn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  fracn_cfg_t cfg_in,
  input  logic       boundary,
  output fracn_cfg_t cfg_eff,
  output fracn_cfg_t cfg_act,
  output logic       restart
);
  fracn_cfg_t pend_q, pend_d;
  fracn_cfg_t act_q,  act_d;
  logic       pvld_q, pvld_d;
  logic       pend_en, act_en;

  always_comb begin
    pend_en = load;
    act_en  = boundary;
    pend_d  = cfg_in;
    act_d   = pvld_q ? pend_q : act_q;
    // A load on the boundary edge re-arms the pending flag.
    pvld_d  = load ? 1'b1 : (boundary ? 1'b0 : pvld_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q.int_v  <= INT_W'(INT_LO);
      pend_q.frac_v <= '0;
      pend_q.mod_v  <= MOD_W'(MOD_LO);
      act_q.int_v   <= INT_W'(INT_LO);
      act_q.frac_v  <= '0;
      act_q.mod_v   <= MOD_W'(MOD_LO);
      pvld_q        <= 1'b0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (act_en)  act_q  <= act_d;
      pvld_q <= pvld_d;
    end
  end

  always_comb begin
    cfg_eff = pvld_q ? pend_q : act_q;
    restart = pvld_q;
    cfg_act = act_q;
  end

  AST_APPLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(act_q)) else $error("active set changed off boundary"); // R5
endmodule

// File: rtl/fracn_accum.sv
module fracn_accum
  import fracn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic [MOD_W-1:0] frac,
  input  logic [MOD_W-1:0] modulus,
  output logic             carry,
  output logic [MOD_W-1:0] acc
);
  localparam int SUM_W = MOD_W + 1;

  logic [MOD_W-1:0] acc_q, acc_d, base;
  logic [SUM_W-1:0] sum, wrapped;

  always_comb begin
    base    = restart ? '0 : acc_q;
    sum     = {1'b0, base} + {1'b0, frac};
    carry   = (sum >= {1'b0, modulus});
    wrapped = sum - {1'b0, modulus};
    acc_d   = carry ? wrapped[MOD_W-1:0] : sum[MOD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (step) acc_q <= acc_d;
  end

  assign acc = acc_q;

  AST_ACC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(acc_q)) else $error("accumulator moved mid period"); // R3
endmodule

// File: rtl/fracn_counter.sv
module fracn_counter
  import fracn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAT_W-1:0] next_ratio,
  output logic             terminal,
  output logic [RAT_W-1:0] ratio
);
  logic [RAT_W-1:0] cnt_q, cnt_d;
  logic [RAT_W-1:0] rat_q, rat_d;
  logic             tc;

  always_comb begin
    tc    = (cnt_q == '0);
    cnt_d = tc ? (next_ratio - RAT_W'(1)) : (cnt_q - RAT_W'(1));
    rat_d = tc ? next_ratio : rat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RAT_W'(INT_LO - 1);
      rat_q <= RAT_W'(INT_LO);
    end else begin
      cnt_q <= cnt_d;
      rat_q <= rat_d;
    end
  end

  assign terminal = tc;
  assign ratio    = rat_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc) else $error("pulse wider than one clock"); // R2
  AST_RATIO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(rat_q)) else $error("ratio changed mid period"); // R2
  AST_COUNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < rat_q) else $error("count outside period"); // R2
endmodule

// File: rtl/fracn_div.sv
module fracn_div
  import fracn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [INT_W-1:0] int_in,
  input  logic [MOD_W-1:0] frac_in,
  input  logic [MOD_W-1:0] mod_in,
  output logic             div_pulse,
  output logic [RAT_W-1:0] ratio
);
  logic       rst_meta_q, rst_sync_q;
  fracn_cfg_t cfg_c, cfg_eff, cfg_act;
  logic       restart, boundary, carry;
  logic [MOD_W-1:0] acc;
  logic [RAT_W-1:0] next_ratio;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  fracn_clamp u_clamp (
    .raw_int  (int_in),
    .raw_frac (frac_in),
    .raw_mod  (mod_in),
    .cfg_c    (cfg_c)
  );

  fracn_cfg_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load     (load),
    .cfg_in   (cfg_c),
    .boundary (boundary),
    .cfg_eff  (cfg_eff),
    .cfg_act  (cfg_act),
    .restart  (restart)
  );

  fracn_accum u_accum (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .step     (boundary),
    .restart  (restart),
    .frac     (cfg_eff.frac_v),
    .modulus  (cfg_eff.mod_v),
    .carry    (carry),
    .acc      (acc)
  );

  always_comb begin
    next_ratio = {1'b0, cfg_eff.int_v} + RAT_W'(carry);
  end

  fracn_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .next_ratio (next_ratio),
    .terminal   (boundary),
    .ratio      (ratio)
  );

  assign div_pulse = boundary;

  AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    acc < cfg_act.mod_v) else $error("accumulator not below modulus"); // R3
  AST_RATIO_BOUNDS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (ratio >= RAT_W'(INT_LO)) && (ratio <= RAT_W'(INT_HI + 1))) else $error("ratio out of range"); // R6
  AST_MOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cfg_c.mod_v >= MOD_W'(MOD_LO)) else $error("modulus under floor"); // R7
  AST_FRAC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cfg_c.frac_v < cfg_c.mod_v) else $error("fraction not below modulus"); // R8
endmodule

// File: tb/tb_fracn_div.sv
module tb_fracn_div;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 190000;

  logic        clk, rst_n, load;
  logic [8:0]  int_in;
  logic [11:0] frac_in, mod_in;
  logic        div_pulse;
  logic [9:0]  ratio;

  int n_vec, n_bad, cyc;
  int li, lf, lm;

  fracn_div dut (
    .clk(clk), .rst_n(rst_n), .load(load), .int_in(int_in),
    .frac_in(frac_in), .mod_in(mod_in), .div_pulse(div_pulse), .ratio(ratio)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void clampv(input int i, input int f, input int m,
                                 output int ci, output int cf, output int cm);
    ci = (i < 31) ? 31 : ((i > 511) ? 511 : i);
    cm = (m < 2) ? 2 : m;
    cf = (f >= cm) ? cm - 1 : f;
  endfunction

  task automatic do_load(input int i, input int f, input int m);
    load = 1'b1; int_in = 9'(i); frac_in = 12'(f); mod_in = 12'(m);
    @(negedge clk);
    load = 1'b0;
    clampv(i, f, m, li, lf, lm);
  endtask

  task automatic wait_boundary();
    while (!div_pulse) @(negedge clk);
  endtask

  // Starting at a boundary negedge, measure n periods from a cleared accumulator.
  task automatic run_periods(input int n, input string tag, output int plus);
    int acc;
    acc = 0; plus = 0;
    for (int k = 0; k < n; k++) begin
      int s, e, cnt;
      s = acc + lf;
      if (s >= lm) begin e = li + 1; acc = s - lm; plus++; end
      else begin e = li; acc = s; end
      @(negedge clk);
      chk(div_pulse == 1'b0, "R2 pulse width", int'(div_pulse), 0);
      chk(int'(ratio) == e, {tag, " ratio"}, int'(ratio), e);
      cnt = 1;
      while (!div_pulse) begin @(negedge clk); cnt++; end
      chk(cnt == e, "R2 period length", cnt, e);
    end
  endtask

  task automatic apply_and_check(input int i, input int f, input int m, input string tag);
    int plus;
    do_load(i, f, m);
    wait_boundary();
    run_periods(lm, tag, plus);
    chk(plus == lf, "R4 INT+1 count over MOD periods", plus, lf);
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG_CYCLES) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG_CYCLES);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int plus;
    process::self().srandom(32'd1234);
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0; load = 1'b0; int_in = '0; frac_in = '0; mod_in = '0;
    li = 31; lf = 0; lm = 2;
    repeat (3) @(negedge clk);
    chk(ratio == 10'd31, "R1 ratio in reset", int'(ratio), 31);
    chk(div_pulse == 1'b0, "R1 pulse in reset", int'(div_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ratio == 10'd31, "R1 ratio after release", int'(ratio), 31);
    wait_boundary();
    run_periods(3, "R1 default", plus);

    // Main function, R3 R4 R5
    apply_and_check(66, 30, 130, "R3 main");
    apply_and_check(40, 0, 17, "R3 zero frac");
    apply_and_check(511, 2, 3, "R3 top ratio");
    apply_and_check(45, 1, 2, "R5 half");
    // Clamps
    apply_and_check(5, 0, 10, "R6 int low");
    apply_and_check(20, 3, 7, "R6 int low frac");
    apply_and_check(40, 1, 0, "R7 mod zero");
    apply_and_check(50, 9, 1, "R7 mod one");
    apply_and_check(40, 200, 100, "R8 frac over");
    apply_and_check(35, 5, 5, "R8 frac equal");

    // R9: loads on the boundary edge and again before the next boundary
    begin
      int oi;
      oi = li;
      @(negedge clk);
      wait_boundary();
      load = 1'b1; int_in = 9'd50; frac_in = 12'd1; mod_in = 12'd4;
      @(negedge clk);
      int_in = 9'd60; frac_in = 12'd2; mod_in = 12'd5;
      @(negedge clk);
      load = 1'b0;
      clampv(60, 2, 5, li, lf, lm);
      chk((int'(ratio) == oi) || (int'(ratio) == oi + 1), "R9 period keeps old ratio", int'(ratio), oi);
      wait_boundary();
      run_periods(lm, "R9 last load wins", plus);
      chk(plus == lf, "R9 INT+1 count", plus, lf);
    end

    // Constrained random
    for (int t = 0; t < 25; t++) begin
      int ri, rf, rm;
      ri = 20 + int'($urandom_range(0, 70));
      rm = int'($urandom_range(0, 48));
      rf = int'($urandom_range(0, 60));
      apply_and_check(ri, rf, rm, "R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule